// File: doc/BRIEF.md
# Open-Row SDRAM Bank Tracker

This block sits between a processor-side request port and an SDR SDRAM command sequencer. Each accepted byte address is split into a bank, a row and a column. Consecutive 2 kB rows rotate through the 8 banks, so two addresses share a bank only when they are a multiple of 16 kB apart. The block remembers which row, if any, is open in every bank. From that record it sorts each access into one of three kinds: the row is already open (hit), the bank has nothing open (closed), or the bank holds a different row (conflict).

For each access the block then emits the commands the sequencer must run, one per cycle, followed by the column command. The column command carries the kind and a latency class: 3 clocks for a hit, 4 clocks for the other two kinds. Rows are never closed after an access. The only exceptions are a conflict, which precharges that one bank, and a precharge-all request (used ahead of refresh), which closes every bank. Only one request is in flight at a time, and the request port is held not-ready while a sequence runs.

Top module: `sdram_open_row_tracker`

## Requirements
- R1: With default parameters the address splits as bank = addr[13:11], row = addr[25:14] and column = addr[10:2]. Bank, row and column appear on cmd_bank_o, cmd_row_o and cmd_col_o with every command of the access.
- R2: An access to the row open in its bank gives a single column command in the cycle after acceptance, with cmd_kind_o = 0 and cmd_slow_o = 0 (3-clock class).
- R3: An access to a bank with no open row gives an activate of the new row and then the column command, with cmd_kind_o = 1 and cmd_slow_o = 1 (4-clock class).
- R4: An access to a bank holding a different row gives a precharge of that bank, an activate of the new row and then the column command, with cmd_kind_o = 2 and cmd_slow_o = 1.
- R5: A row stays open after every access. Accesses to other banks do not close it, and a later access to the same row is a hit.
- R6: req_ready_o is high only while no sequence is running and flush_i is low. A request is taken only on a cycle with req_valid_i and req_ready_o both high, and the request port is held low through every command cycle.
- R7: When flush_i is high while the block is idle, a single precharge-all command is issued and all banks become closed. flush_i takes priority over a request presented in the same cycle, and that request is taken afterwards as a closed-bank access.
- R8: cmd_op_o encodes 0 = none, 1 = precharge, 2 = activate, 3 = read, 4 = write, 5 = precharge-all. cmd_valid_o is high exactly when cmd_op_o is nonzero, at most one command is issued per cycle, and the column command is a read or write according to req_we_i (1 = write).
- R9: After reset all banks are closed, req_ready_o is high and no command is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be taken this cycle |
| req_addr_i | input | ADDR_W (26) | Byte address |
| req_we_i | input | 1 | 1 = write, 0 = read |
| flush_i | input | 1 | Close all banks (precharge-all) |
| cmd_valid_o | output | 1 | Command issued this cycle |
| cmd_op_o | output | 3 | Command code |
| cmd_bank_o | output | BANK_W (3) | Target bank |
| cmd_row_o | output | ROW_W (12) | Row for activate |
| cmd_col_o | output | COL_W (9) | Column for read/write |
| cmd_kind_o | output | 2 | 0 hit, 1 closed, 2 conflict (with column command) |
| cmd_slow_o | output | 1 | Latency class: 0 = 3 clocks, 1 = 4 clocks |

## Verification
A wrong open-row record does not stay hidden. The next access to the affected bank shows the wrong number of command cycles and a wrong cmd_kind_o and cmd_slow_o on its column command, within three cycles of acceptance. A stale row that was never updated turns an expected hit into a conflict, or the reverse. A flush that fails to clear a bank makes the next access there report a hit or conflict instead of a closed bank. The stimulus reuses a few rows per bank so that all three kinds keep occurring, and flushes now and then to reset the record.

// File: rtl/ort_pkg.sv
package ort_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_PRE  = 3'd1,
    OP_ACT  = 3'd2,
    OP_RD   = 3'd3,
    OP_WR   = 3'd4,
    OP_PALL = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    K_HIT      = 2'd0,
    K_CLOSED   = 2'd1,
    K_CONFLICT = 2'd2
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PRE,
    S_ACT,
    S_COL,
    S_PALL
  } seq_state_e;
endpackage

// File: rtl/ort_addr_map.sv
module ort_addr_map #(
  parameter int ADDR_W    = 26,
  parameter int ROW_BYTES = 2048,
  parameter int NUM_BANKS = 8,
  parameter int BUS_BYTES = 4,
  localparam int OFS_W  = $clog2(ROW_BYTES),
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int BYTE_W = $clog2(BUS_BYTES),
  localparam int ROW_W  = ADDR_W - OFS_W - BANK_W,
  localparam int COL_W  = OFS_W - BYTE_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o
);
  // bank field sits right above the row offset: rows rotate across banks
  assign col_o  = addr_i[OFS_W-1:BYTE_W];
  assign bank_o = addr_i[OFS_W+BANK_W-1:OFS_W];
  assign row_o  = addr_i[ADDR_W-1:OFS_W+BANK_W];
endmodule

// File: rtl/ort_bank_table.sv
module ort_bank_table #(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 12,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [BANK_W-1:0] wr_bank_i,
  input  logic [ROW_W-1:0]  wr_row_i,
  input  logic              clr_all_i,
  input  logic [BANK_W-1:0] rd_bank_i,
  output logic              open_valid_o,
  output logic [ROW_W-1:0]  open_row_o
);
  logic [NUM_BANKS-1:0] valid_q;
  logic [ROW_W-1:0]     row_q [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[b] <= 1'b0;
        row_q[b]   <= '0;
      end else if (clr_all_i) begin
        valid_q[b] <= 1'b0;
      end else if (wr_en_i && wr_bank_i == BANK_W'(b)) begin
        valid_q[b] <= 1'b1;
        row_q[b]   <= wr_row_i;
      end
    end
  end

  assign open_valid_o = valid_q[rd_bank_i];
  assign open_row_o   = row_q[rd_bank_i];
endmodule

// File: rtl/ort_cmd_seq.sv
module ort_cmd_seq
  import ort_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  kind_e start_kind_i,
  input  logic  flush_i,
  output logic  idle_o,
  output logic  pre_o,
  output logic  act_o,
  output logic  col_o,
  output logic  pall_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: begin
        if (flush_i) state_d = S_PALL;
        else if (start_i) begin
          unique case (start_kind_i)
            K_HIT:      state_d = S_COL;
            K_CLOSED:   state_d = S_ACT;
            K_CONFLICT: state_d = S_PRE;
            default:    state_d = S_PRE;
          endcase
        end
      end
      S_PRE:   state_d = S_ACT;
      S_ACT:   state_d = S_COL;
      S_COL:   state_d = S_IDLE;
      S_PALL:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  assign idle_o = state_q == S_IDLE;
  assign pre_o  = state_q == S_PRE;
  assign act_o  = state_q == S_ACT;
  assign col_o  = state_q == S_COL;
  assign pall_o = state_q == S_PALL;
endmodule

// File: rtl/sdram_open_row_tracker.sv
module sdram_open_row_tracker
  import ort_pkg::*;
#(
  parameter int ADDR_W    = 26,
  parameter int ROW_BYTES = 2048,
  parameter int NUM_BANKS = 8,
  parameter int BUS_BYTES = 4,
  localparam int OFS_W  = $clog2(ROW_BYTES),
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int BYTE_W = $clog2(BUS_BYTES),
  localparam int ROW_W  = ADDR_W - OFS_W - BANK_W,
  localparam int COL_W  = OFS_W - BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_we_i,
  input  logic              flush_i,
  output logic              cmd_valid_o,
  output logic [2:0]        cmd_op_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ROW_W-1:0]  cmd_row_o,
  output logic [COL_W-1:0]  cmd_col_o,
  output logic [1:0]        cmd_kind_o,
  output logic              cmd_slow_o
);
  logic [BANK_W-1:0] in_bank;
  logic [ROW_W-1:0]  in_row;
  logic [COL_W-1:0]  in_col;
  logic              open_valid;
  logic [ROW_W-1:0]  open_row;
  kind_e             in_kind;
  logic              idle, pre, act, col, pall, accept;

  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              we_q;
  kind_e             kind_q;

  ort_addr_map #(
    .ADDR_W(ADDR_W), .ROW_BYTES(ROW_BYTES),
    .NUM_BANKS(NUM_BANKS), .BUS_BYTES(BUS_BYTES)
  ) u_map (
    .addr_i(req_addr_i),
    .bank_o(in_bank),
    .row_o (in_row),
    .col_o (in_col)
  );

  ort_bank_table #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (act),
    .wr_bank_i   (bank_q),
    .wr_row_i    (row_q),
    .clr_all_i   (pall),
    .rd_bank_i   (in_bank),
    .open_valid_o(open_valid),
    .open_row_o  (open_row)
  );

  always_comb begin
    if (!open_valid)            in_kind = K_CLOSED;
    else if (open_row == in_row) in_kind = K_HIT;
    else                        in_kind = K_CONFLICT;
  end

  // precharge-all wins over a request in the same cycle
  assign req_ready_o = idle && !flush_i;
  assign accept      = req_valid_i && req_ready_o;

  ort_cmd_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (accept),
    .start_kind_i(in_kind),
    .flush_i     (flush_i),
    .idle_o      (idle),
    .pre_o       (pre),
    .act_o       (act),
    .col_o       (col),
    .pall_o      (pall)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
      we_q   <= 1'b0;
      kind_q <= K_HIT;
    end else if (accept) begin
      bank_q <= in_bank;
      row_q  <= in_row;
      col_q  <= in_col;
      we_q   <= req_we_i;
      kind_q <= in_kind;
    end
  end

  always_comb begin
    cmd_op_o = OP_NOP;
    if (pre)       cmd_op_o = OP_PRE;
    else if (act)  cmd_op_o = OP_ACT;
    else if (col)  cmd_op_o = we_q ? OP_WR : OP_RD;
    else if (pall) cmd_op_o = OP_PALL;
  end

  assign cmd_valid_o = !idle;
  assign cmd_bank_o  = bank_q;
  assign cmd_row_o   = row_q;
  assign cmd_col_o   = col_q;
  assign cmd_kind_o  = kind_q;
  assign cmd_slow_o  = kind_q != K_HIT;
endmodule

// File: rtl/ort_checker.sv
module ort_checker #(
  parameter int ADDR_W = 26,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              req_we_i,
  input logic              flush_i,
  input logic              cmd_valid_o,
  input logic [2:0]        cmd_op_o,
  input logic [BANK_W-1:0] cmd_bank_o,
  input logic [ROW_W-1:0]  cmd_row_o,
  input logic [COL_W-1:0]  cmd_col_o,
  input logic [1:0]        cmd_kind_o,
  input logic              cmd_slow_o
);
  logic is_col;
  assign is_col = cmd_op_o == 3'd3 || cmd_op_o == 3'd4;

  p_pre_then_act_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_op_o == 3'd1 |=> cmd_op_o == 3'd2 && cmd_bank_o == $past(cmd_bank_o));

  p_act_then_col_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_op_o == 3'd2 |=> is_col && cmd_bank_o == $past(cmd_bank_o)
                         && cmd_row_o == $past(cmd_row_o));

  p_hit_no_act_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_col && cmd_kind_o == 2'd0 |-> !cmd_slow_o && $past(cmd_op_o) != 3'd2);

  p_miss_slow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_col && cmd_kind_o != 2'd0 |-> cmd_slow_o && $past(cmd_op_o) == 3'd2);

  p_busy_not_ready_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> !req_ready_o);

  p_accept_issues_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> cmd_valid_o && cmd_op_o != 3'd5);

  p_valid_matches_op_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o == (cmd_op_o != 3'd0));

  p_pall_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_op_o == 3'd5 |=> !cmd_valid_o);
endmodule

bind sdram_open_row_tracker ort_checker #(
  .ADDR_W(ADDR_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)
) u_chk (.*);

// File: tb/sdram_open_row_tracker_tb.sv
module sdram_open_row_tracker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [25:0] req_addr_i = '0;
  logic        req_we_i = 1'b0;
  logic        flush_i = 1'b0;
  logic        cmd_valid_o;
  logic [2:0]  cmd_op_o;
  logic [2:0]  cmd_bank_o;
  logic [11:0] cmd_row_o;
  logic [8:0]  cmd_col_o;
  logic [1:0]  cmd_kind_o;
  logic        cmd_slow_o;

  int n_chk = 0;
  int n_fail = 0;

  logic        m_valid [8];
  logic [11:0] m_row [8];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sdram_open_row_tracker u_dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [25:0] mk_addr(input int row, input int bank, input int col);
    return {12'(row), 3'(bank), 9'(col), 2'b00};
  endfunction

  function automatic int exp_kind(input int bank, input int row);
    if (!m_valid[bank]) return 1;
    if (m_row[bank] == 12'(row)) return 0;
    return 2;
  endfunction

  task automatic do_access(input logic [25:0] a, input bit we);
    int bank, row, col, k;
    bank = int'(a[13:11]);
    row  = int'(a[25:14]);
    col  = int'(a[10:2]);
    @(negedge clk_i);
    while (!req_ready_o) @(negedge clk_i);
    chk(!cmd_valid_o, "R8 no command while idle", int'(cmd_valid_o), 0);
    req_valid_i = 1'b1;
    req_addr_i  = a;
    req_we_i    = we;
    k = exp_kind(bank, row);
    if (k == 2) begin
      @(negedge clk_i);
      req_valid_i = 1'b0;
      chk(cmd_op_o == 3'd1, "R4 precharge first", int'(cmd_op_o), 1);
      chk(cmd_bank_o == 3'(bank), "R1 precharge bank", int'(cmd_bank_o), bank);
      chk(!req_ready_o, "R6 ready low in precharge", int'(req_ready_o), 0);
    end
    if (k != 0) begin
      @(negedge clk_i);
      req_valid_i = 1'b0;
      chk(cmd_op_o == 3'd2, "R3 activate", int'(cmd_op_o), 2);
      chk(cmd_bank_o == 3'(bank), "R1 activate bank", int'(cmd_bank_o), bank);
      chk(cmd_row_o == 12'(row), "R1 activate row", int'(cmd_row_o), row);
      chk(!req_ready_o, "R6 ready low in activate", int'(req_ready_o), 0);
    end
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(cmd_valid_o && cmd_op_o == (we ? 3'd4 : 3'd3), "R8 column op",
        int'(cmd_op_o), we ? 4 : 3);
    chk(cmd_bank_o == 3'(bank), "R1 column bank", int'(cmd_bank_o), bank);
    chk(cmd_col_o == 9'(col), "R1 column", int'(cmd_col_o), col);
    chk(cmd_kind_o == 2'(k), k == 0 ? "R2 kind hit" : (k == 1 ? "R3 kind closed" : "R4 kind conflict"),
        int'(cmd_kind_o), k);
    chk(cmd_slow_o == (k != 0), k == 0 ? "R2 latency class" : "R3 latency class",
        int'(cmd_slow_o), int'(k != 0));
    chk(!req_ready_o, "R6 ready low in column", int'(req_ready_o), 0);
    m_valid[bank] = 1'b1;
    m_row[bank]   = 12'(row);
  endtask

  task automatic do_flush(input bit with_req, input logic [25:0] a, input bit we);
    @(negedge clk_i);
    while (!req_ready_o) @(negedge clk_i);
    flush_i = 1'b1;
    if (with_req) begin
      req_valid_i = 1'b1;
      req_addr_i  = a;
      req_we_i    = we;
    end
    #1;
    chk(!req_ready_o, "R7 flush blocks ready", int'(req_ready_o), 0);
    @(negedge clk_i);
    chk(cmd_valid_o && cmd_op_o == 3'd5, "R7 precharge-all", int'(cmd_op_o), 5);
    flush_i = 1'b0;
    for (int b = 0; b < 8; b++) m_valid[b] = 1'b0;
    if (with_req) do_access(a, we);
  endtask

  initial begin
    #(CLK_PERIOD * MAX_CYCLES);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed_0c0d);
    for (int b = 0; b < 8; b++) begin
      m_valid[b] = 1'b0;
      m_row[b]   = '0;
    end
    #(CLK_PERIOD * 3 + 2);
    chk(!cmd_valid_o && cmd_op_o == 3'd0, "R9 no command in reset", int'(cmd_op_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o, "R9 ready after reset", int'(req_ready_o), 1);
    chk(!cmd_valid_o, "R9 idle after reset", int'(cmd_valid_o), 0);

    // directed: closed, hit, other bank, hit again, conflict 16 kB apart
    do_access(mk_addr(5, 2, 17), 1'b0);
    do_access(mk_addr(5, 2, 300), 1'b1);
    do_access(mk_addr(9, 3, 0), 1'b0);
    do_access(mk_addr(5, 2, 511), 1'b0);
    do_access(mk_addr(6, 2, 4), 1'b1);
    do_access(mk_addr(6, 2, 4), 1'b0);
    chk(m_valid[3] && m_row[3] == 12'd9, "R5 model keeps bank3 open", 1, 1);
    do_access(mk_addr(9, 3, 1), 1'b0);

    // flush alone, then flush with a request in the same cycle
    do_flush(1'b0, '0, 1'b0);
    do_access(mk_addr(6, 2, 8), 1'b0);
    do_access(mk_addr(9, 3, 8), 1'b1);
    do_flush(1'b1, mk_addr(9, 3, 2), 1'b0);
    do_access(mk_addr(9, 3, 3), 1'b0);

    for (int i = 0; i < 1500; i++) begin
      int r;
      r = int'($urandom % 41);
      if (r == 0) do_flush(1'($urandom % 2), mk_addr(int'($urandom % 3), int'($urandom % 8),
                           int'($urandom % 512)), 1'($urandom % 2));
      else do_access(mk_addr(int'($urandom % 3), int'($urandom % 8), int'($urandom % 512)),
                     1'($urandom % 2));
    end

    @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule